// File: doc/BRIEF.md
# Parallel Bit Extract/Deposit Unit

This block rearranges the bits of an N-bit data word under the control of an N-bit mask. In gather mode it takes every data bit that sits under a set mask bit and packs those bits, in their original relative order, into the low end of the result. In scatter mode it works the other way round. It takes the low-order data bits in order and places each one at the next set mask position, scanning from the least significant end upward.

A request is one operation select, one data word and one mask, qualified by a valid strobe. The result and an output valid flag appear on the clock edge after the request. The registered result keeps its value until the next accepted request. Both modes share one rank computation: for each mask position, the number of set mask bits below it. That rank is the result index in gather mode and the source index in scatter mode.

Top module: `pbx_unit`

## Requirements
- R1: With `in_op` = 0 (gather), result bit k equals the data bit at the position of the k-th set mask bit, counting from bit 0 upward with k starting at 0.
- R2: In gather mode, every result bit at index popcount(mask) or above is 0.
- R3: With `in_op` = 1 (scatter), at the position of the k-th set mask bit the result holds data bit k.
- R4: In scatter mode, every result bit whose mask bit is 0 is 0.
- R5: A scatter under mask m applied to the result of a gather of d under the same m gives d AND m.
- R6: An all-zero mask gives a zero result in both modes. An all-ones mask returns the data unchanged in both modes.
- R7: A request presented with `in_valid` high at a rising edge appears on `out_result` after that edge, and `out_valid` at each edge takes the value `in_valid` had at that edge.
- R8: While `in_valid` is low, `out_result` holds its value whatever `in_op`, `in_data` and `in_mask` do.
- R9: A synchronous active-high `rst` clears `out_result` to 0 and `out_valid` to 0 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_op | input | 1 | 0 = gather, 1 = scatter |
| in_data | input | N | Data word |
| in_mask | input | N | Selection mask |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | N | Registered result |

## Verification
Every result is due exactly one rising edge after its request is sampled. The bench therefore drives the request on a falling edge, lets one rising edge pass, and reads `out_result` and `out_valid` on the following falling edge, before anything else changes. The hold check drives new operands with the strobe low and then reads the output several falling edges later. The inverse check feeds the sampled gather result back in as the data of a scatter request under the same mask.

// File: rtl/pbx_pkg.sv
package pbx_pkg;

    typedef enum logic {
        OP_GATHER  = 1'b0,
        OP_SCATTER = 1'b1
    } pbx_op_e;

    // Width of a count of 0..n set bits
    function automatic int cnt_w(input int n);
        return $clog2(n + 1);
    endfunction

    // Width of an index into n bits
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pbx_rank.sv
module pbx_rank
    import pbx_pkg::*;
#(
    parameter int N  = 32,
    parameter int CW = cnt_w(N)
) (
    input  logic [N-1:0]         mask,
    output logic [N-1:0][CW-1:0] rank
);
    // rank[i] = number of set mask bits strictly below position i
    always_comb begin
        logic [CW-1:0] acc;
        acc = '0;
        for (int i = 0; i < N; i++) begin
            rank[i] = acc;
            acc     = acc + CW'(mask[i]);
        end
    end
endmodule

// File: rtl/pbx_gather.sv
module pbx_gather
    import pbx_pkg::*;
#(
    parameter int N  = 32,
    parameter int CW = cnt_w(N),
    parameter int IW = idx_w(N)
) (
    input  logic [N-1:0]         data,
    input  logic [N-1:0]         mask,
    input  logic [N-1:0][CW-1:0] rank,
    output logic [N-1:0]         res
);
    // A selected bit's rank never exceeds N-1, so IW bits index it.
    always_comb begin
        res = '0;
        for (int i = 0; i < N; i++) begin
            if (mask[i]) res[rank[i][IW-1:0]] = data[i];
        end
    end
endmodule

// File: rtl/pbx_scatter.sv
module pbx_scatter
    import pbx_pkg::*;
#(
    parameter int N  = 32,
    parameter int CW = cnt_w(N),
    parameter int IW = idx_w(N)
) (
    input  logic [N-1:0]         data,
    input  logic [N-1:0]         mask,
    input  logic [N-1:0][CW-1:0] rank,
    output logic [N-1:0]         res
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            assign res[i] = mask[i] & data[rank[i][IW-1:0]];
        end
    endgenerate
endmodule

// File: rtl/pbx_unit.sv
module pbx_unit
    import pbx_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_op,
    input  logic [N-1:0] in_data,
    input  logic [N-1:0] in_mask,
    output logic         out_valid,
    output logic [N-1:0] out_result
);
    localparam int CW = cnt_w(N);
    localparam int IW = idx_w(N);

    pbx_op_e             op;
    logic [N-1:0][CW-1:0] rank;
    logic [N-1:0]         gat_res;
    logic [N-1:0]         sct_res;
    logic [N-1:0]         nxt_res;

    assign op = pbx_op_e'(in_op);

    pbx_rank #(.N(N), .CW(CW)) u_rank (
        .mask (in_mask),
        .rank (rank)
    );

    pbx_gather #(.N(N), .CW(CW), .IW(IW)) u_gather (
        .data (in_data),
        .mask (in_mask),
        .rank (rank),
        .res  (gat_res)
    );

    pbx_scatter #(.N(N), .CW(CW), .IW(IW)) u_scatter (
        .data (in_data),
        .mask (in_mask),
        .rank (rank),
        .res  (sct_res)
    );

    always_comb begin
        unique case (op)
            OP_GATHER:  nxt_res = gat_res;
            OP_SCATTER: nxt_res = sct_res;
            default:    nxt_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_result <= nxt_res;
        end
    end
endmodule

// File: rtl/pbx_unit_chk.sv
module pbx_unit_chk #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_op,
    input logic [N-1:0] in_data,
    input logic [N-1:0] in_mask,
    input logic         out_valid,
    input logic [N-1:0] out_result
);
    // R2
    gather_high_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op) |=>
            ((out_result >> $past($countones(in_mask))) == '0));

    // R1
    gather_count_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op) |=>
            ($countones(out_result) == $past($countones(in_data & in_mask))));

    // R4
    scatter_unmasked_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op) |=> ((out_result & ~$past(in_mask)) == '0));

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0));
endmodule

bind pbx_unit pbx_unit_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_data    (in_data),
    .in_mask    (in_mask),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/pbx_unit_tb.sv
module pbx_unit_tb;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_op;
    logic [N-1:0] in_data;
    logic [N-1:0] in_mask;
    logic         out_valid;
    logic [N-1:0] out_result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pbx_unit #(.N(N)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_data(in_data), .in_mask(in_mask),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [N-1:0] ref_gather(input logic [N-1:0] d, input logic [N-1:0] m);
        logic [N-1:0] r = '0;
        int k = 0;
        for (int i = 0; i < N; i++) if (m[i]) begin r[k] = d[i]; k++; end
        return r;
    endfunction

    function automatic logic [N-1:0] ref_scatter(input logic [N-1:0] d, input logic [N-1:0] m);
        logic [N-1:0] r = '0;
        int k = 0;
        for (int i = 0; i < N; i++) if (m[i]) begin r[i] = d[k]; k++; end
        return r;
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive on a falling edge, one rising edge registers, sample on the next falling edge.
    task automatic run(input logic op, input logic [N-1:0] d, input logic [N-1:0] m);
        in_valid = 1'b1; in_op = op; in_data = d; in_mask = m;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_check(input string req, input logic op,
                             input logic [N-1:0] d, input logic [N-1:0] m);
        run(op, d, m);
        check({req, " valid"}, N'(out_valid), N'(1));
        check(req, out_result, op ? ref_scatter(d, m) : ref_gather(d, m));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] d, m, g, held;
        void'($urandom(32'd1234));
        rst = 1'b1; in_valid = 1'b1; in_op = 1'b1; in_data = '1; in_mask = '1;
        repeat (3) @(negedge clk);
        // R9: reset wins over a valid request
        check("R9 result", out_result, '0);
        check("R9 valid", N'(out_valid), '0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        // R1, R2 directed
        run_check("R1", 1'b0, 32'hA5A5_F00F, 32'h0F0F_0F0F);
        check("R2", out_result >> 16, '0);
        run_check("R1", 1'b0, 32'h8000_0001, 32'h8000_0001);
        check("R2", out_result, 32'h3);
        // R3, R4 directed
        run_check("R3", 1'b1, 32'h0000_00B7, 32'hF000_000F);
        check("R4", out_result & ~32'hF000_000F, '0);
        run_check("R3", 1'b1, 32'h0000_0002, 32'h8000_0001);
        check("R3 top bit", out_result, 32'h8000_0000);
        // R6
        run_check("R6 zero gather", 1'b0, 32'hDEAD_BEEF, '0);
        check("R6 zero gather", out_result, '0);
        run_check("R6 zero scatter", 1'b1, 32'hDEAD_BEEF, '0);
        check("R6 zero scatter", out_result, '0);
        run_check("R6 ones gather", 1'b0, 32'h1357_9BDF, '1);
        check("R6 ones gather", out_result, 32'h1357_9BDF);
        run_check("R6 ones scatter", 1'b1, 32'h2468_ACE0, '1);
        check("R6 ones scatter", out_result, 32'h2468_ACE0);

        // R8: operands move with strobe low
        held = out_result;
        in_op = 1'b0; in_data = 32'h1111_1111; in_mask = 32'hFFFF_0000;
        repeat (3) @(negedge clk);
        in_data = 32'h7777_0000; in_op = 1'b1;
        @(negedge clk);
        check("R8 hold", out_result, held);
        check("R7 valid low", N'(out_valid), '0);

        // R7: back-to-back requests
        in_valid = 1'b1; in_op = 1'b0; in_data = 32'hFFFF_FFFF; in_mask = 32'h0000_00F0;
        @(negedge clk);
        check("R7 first", out_result, 32'h0000_000F);
        in_op = 1'b1; in_data = 32'h0000_0005; in_mask = 32'hF000_0000;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 second", out_result, 32'h5000_0000);
        check("R7 valid", N'(out_valid), N'(1));

        // Random mix, R1 R3 R5
        for (int t = 0; t < 300; t++) begin
            d = $urandom(); m = $urandom();
            if (t % 5 == 1) m = m & $urandom();
            if (t % 5 == 2) m = m | $urandom();
            run_check("R1", 1'b0, d, m);
            g = out_result;
            run_check("R3", 1'b1, d, m);
            run(1'b1, g, m);
            check("R5 inverse", out_result, d & m);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule